// File: doc/BRIEF.md
# Four-Operand Signed Add-Subtract Unit

This block is a purely combinational datapath. It takes four narrow two's-complement operands, called A, B, C and D, and returns the signed difference of two pair sums, A + B - C - D. The result is just wide enough to hold every value the operands can produce, so it never wraps.

The unit first forms two partial sums, A + B and C + D. Each partial sum comes from a ripple-carry adder one bit wider than the operands, and the operands are sign-extended before they enter it. A third ripple adder, two bits wider than the operands, then subtracts the second partial sum from the first. It does this by adding the bitwise inverse of the widened second sum and setting its carry-in to one.

Every carry-out is discarded. The datapath has no clock, no state and no flags. Surrounding logic uses it wherever a registered stage needs the pair-sum difference within one cycle.

Top module: `quad_addsub_unit`

## Requirements
- R1: For every one of the 65536 input combinations, `result` read as a 6-bit two's-complement number equals A + B - C - D, with each 4-bit input read as two's complement.
- R2: An input with bit 3 set counts as negative. For example, 4'b1000 is -8 and 4'b1111 is -1, so A = 4'b1000 with B = C = D = 0 gives `result` = 6'b111000 (-8).
- R3: The most negative result is A = B = -8 with C = D = +7, which gives -30, encoded as 6'b100010.
- R4: The most positive result is A = B = +7 with C = D = -8, which gives +30, encoded as 6'b011110.
- R5: Whenever A + B equals C + D, `result` is 6'b000000. This includes the case where all inputs are zero.
- R6: The output settles from the present inputs alone, with no clock edge in between. A new set of inputs is reflected without any earlier inputs affecting it.
- R7: Bit 5 of `result` is 1 exactly when A + B is less than C + D.
- R8: Exchanging A with B, or C with D, leaves `result` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 4 | First addend, signed |
| opnd_b | input | 4 | Second addend, signed |
| opnd_c | input | 4 | First subtrahend, signed |
| opnd_d | input | 4 | Second subtrahend, signed |
| result | output | 6 | A + B - C - D, signed |

## Verification
The bench builds the unit with the package default of 4-bit operands. At that width the whole input space has only 65536 points, so every operand combination is compared against an integer model computed in the bench. The same build also lets the bench hit the two exact range extremes of -30 and +30 and the sign-bit boundary where the two pair sums are equal. Directed cases on top of the sweep target signed reading of the inputs, operand swapping, and input changes with no clock edge between them.

// File: rtl/qas_pkg.sv
package qas_pkg;

    // Operand width; all other widths follow from it.
    parameter int OPERAND_W = 4;

    // Pair-sum width: one guard bit above the operands.
    localparam int PARTIAL_W = OPERAND_W + 1;

    // Result width: one further guard bit for the subtraction.
    localparam int RESULT_W  = OPERAND_W + 2;

    // Largest result magnitude: two most-negative operands minus two most-positive ones.
    localparam int RESULT_LIMIT = 2 * (2 ** (OPERAND_W - 1)) + 2 * (2 ** (OPERAND_W - 1) - 1);

    // A partial sum together with its adder's carry-out.
    typedef struct packed {
        logic [PARTIAL_W-1:0] sum;
        logic                 carry;
    } partial_t;

    // Replicate the operand sign bit up to the pair-sum width.
    function automatic logic [PARTIAL_W-1:0] widen_operand(input logic [OPERAND_W-1:0] v);
        return {v[OPERAND_W-1], v};
    endfunction

    // Replicate the pair-sum sign bit up to the result width.
    function automatic logic [RESULT_W-1:0] widen_partial(input logic [PARTIAL_W-1:0] v);
        return {v[PARTIAL_W-1], v};
    endfunction

endpackage

// File: rtl/qas_full_adder.sv
module qas_full_adder (
    input  logic a,
    input  logic b,
    input  logic ci,
    output logic s,
    output logic co
);

    logic half;

    assign half = a ^ b;
    assign s    = half ^ ci;
    assign co   = (a & b) | (ci & half);

endmodule

// File: rtl/qas_ripple_adder.sv
module qas_ripple_adder #(
    parameter int WIDTH = 5
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);

    logic [WIDTH:0] chain;

    assign chain[0] = cin;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        qas_full_adder u_fa (
            .a  (a[i]),
            .b  (b[i]),
            .ci (chain[i]),
            .s  (sum[i]),
            .co (chain[i+1])
        );
    end

    assign cout = chain[WIDTH];

    // The cell chain must match unsigned addition including the carry-out (supports R1).
    always_comb begin
        // R1
        ripple_sum_chk: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin}))
            else $error("ripple adder mismatch");
    end

endmodule

// File: rtl/quad_addsub_unit.sv
module quad_addsub_unit
    import qas_pkg::*;
(
    input  logic [OPERAND_W-1:0] opnd_a,
    input  logic [OPERAND_W-1:0] opnd_b,
    input  logic [OPERAND_W-1:0] opnd_c,
    input  logic [OPERAND_W-1:0] opnd_d,
    output logic [RESULT_W-1:0]  result
);

    logic [PARTIAL_W-1:0] wide_a, wide_b, wide_c, wide_d;
    partial_t             plus_pair, minus_pair;
    logic [RESULT_W-1:0]  plus_ext, minus_ext, minus_inv;
    logic                 final_carry;

    assign wide_a = widen_operand(opnd_a);
    assign wide_b = widen_operand(opnd_b);
    assign wide_c = widen_operand(opnd_c);
    assign wide_d = widen_operand(opnd_d);

    // First level: A + B.
    logic [PARTIAL_W-1:0] plus_sum;
    logic                 plus_co;
    qas_ripple_adder #(.WIDTH(PARTIAL_W)) u_plus (
        .a    (wide_a),
        .b    (wide_b),
        .cin  (1'b0),
        .sum  (plus_sum),
        .cout (plus_co)
    );

    // First level: C + D.
    logic [PARTIAL_W-1:0] minus_sum;
    logic                 minus_co;
    qas_ripple_adder #(.WIDTH(PARTIAL_W)) u_minus (
        .a    (wide_c),
        .b    (wide_d),
        .cin  (1'b0),
        .sum  (minus_sum),
        .cout (minus_co)
    );

    assign plus_pair  = '{sum: plus_sum,  carry: plus_co};
    assign minus_pair = '{sum: minus_sum, carry: minus_co};

    // Second level: widen both pair sums, subtract by inverting and adding one.
    assign plus_ext  = widen_partial(plus_pair.sum);
    assign minus_ext = widen_partial(minus_pair.sum);
    assign minus_inv = ~minus_ext;

    qas_ripple_adder #(.WIDTH(RESULT_W)) u_diff (
        .a    (plus_ext),
        .b    (minus_inv),
        .cin  (1'b1),
        .sum  (result),
        .cout (final_carry)
    );

    always_comb begin
        // R1
        result_exact_chk: assert ($signed(result) ==
                                  $signed(opnd_a) + $signed(opnd_b) - $signed(opnd_c) - $signed(opnd_d))
            else $error("result differs from signed expression");
        // R3 R4
        result_range_chk: assert (($signed(result) >= -RESULT_LIMIT) && ($signed(result) <= RESULT_LIMIT))
            else $error("result outside reachable range");
        // R7
        sign_order_chk: assert (result[RESULT_W-1] == ($signed(plus_pair.sum) < $signed(minus_pair.sum)))
            else $error("sign bit disagrees with pair-sum order");
        // R1
        pair_exact_chk: assert (($signed(plus_pair.sum) == $signed(opnd_a) + $signed(opnd_b)) &&
                                ($signed(minus_pair.sum) == $signed(opnd_c) + $signed(opnd_d)))
            else $error("pair sum not exact");
        // R1
        borrow_chk: assert (final_carry == (plus_ext >= minus_ext))
            else $error("final carry is not the no-borrow indication");
        // R1
        pair_carry_chk: assert ((plus_pair.carry ==
                                 (({1'b0, wide_a} + {1'b0, wide_b}) > {1'b0, {PARTIAL_W{1'b1}}})) &&
                                (minus_pair.carry ==
                                 (({1'b0, wide_c} + {1'b0, wide_d}) > {1'b0, {PARTIAL_W{1'b1}}})))
            else $error("pair carry-out wrong");
    end

endmodule

// File: tb/quad_addsub_unit_test.sv
module quad_addsub_unit_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] a_in, b_in, c_in, d_in;
    logic [5:0] res;
    int         checks = 0;
    int         fails  = 0;
    int         cycles = 0;

    always #4 clk = ~clk;   // 125 MHz

    quad_addsub_unit uut (
        .opnd_a (a_in),
        .opnd_b (b_in),
        .opnd_c (c_in),
        .opnd_d (d_in),
        .result (res)
    );

    function automatic int sv4(input logic [3:0] v);
        logic signed [3:0] t;
        t = v;
        return int'(t);
    endfunction

    function automatic int model(input logic [3:0] a, input logic [3:0] b,
                                 input logic [3:0] c, input logic [3:0] d);
        return sv4(a) + sv4(b) - sv4(c) - sv4(d);
    endfunction

    function automatic int got_val();
        logic signed [5:0] t;
        t = res;
        return int'(t);
    endfunction

    task automatic drive(input int a, input int b, input int c, input int d);
        a_in = 4'(a); b_in = 4'(b); c_in = 4'(c); d_in = 4'(d);
        #1;
    endtask

    task automatic expect_val(input string req, input int exp);
        checks++;
        if (got_val() != exp) begin
            fails++;
            $display("FAIL %s: a=%0d b=%0d c=%0d d=%0d actual=%0d expected=%0d",
                     req, sv4(a_in), sv4(b_in), sv4(c_in), sv4(d_in), got_val(), exp);
        end
    endtask

    task automatic expect_bits(input string req, input logic [5:0] exp);
        checks++;
        if (res !== exp) begin
            fails++;
            $display("FAIL %s: actual=%b expected=%b", req, res, exp);
        end
    endtask

    // R5: zero inputs give zero
    task automatic t_idle();
        drive(0, 0, 0, 0);
        expect_bits("R5", 6'b000000);
    endtask

    // R2: signed reading of inputs
    task automatic t_signed_read();
        drive(4'b1000, 0, 0, 0);
        expect_bits("R2", 6'b111000);
        drive(4'b1111, 0, 0, 0);
        expect_val("R2", -1);
        drive(0, 0, 4'b1000, 0);
        expect_val("R2", 8);
    endtask

    // R3 R4: extremes
    task automatic t_extremes();
        drive(-8, -8, 7, 7);
        expect_bits("R3", 6'b100010);
        drive(7, 7, -8, -8);
        expect_bits("R4", 6'b011110);
    endtask

    // R5: balanced pairs
    task automatic t_balanced();
        drive(3, -5, -6, 4);
        expect_bits("R5", 6'b000000);
        drive(-8, 7, 7, -8);
        expect_bits("R5", 6'b000000);
    endtask

    // R6: new inputs show without a clock edge, independent of previous ones
    task automatic t_no_clock();
        @(negedge clk);
        drive(7, 7, -8, -8);
        drive(-8, -8, 7, 7);
        expect_val("R6", -30);
        drive(1, 2, 3, -4);
        expect_val("R6", 4);
    endtask

    // R7: sign bit tracks pair-sum order
    task automatic t_sign_bit();
        for (int i = 0; i < 256; i++) begin
            int a, b, c, d;
            a = (i * 7) % 16 - 8;  b = (i * 3) % 16 - 8;
            c = (i * 5) % 16 - 8;  d = (i * 11) % 16 - 8;
            drive(a, b, c, d);
            checks++;
            if (res[5] != ((a + b) < (c + d))) begin
                fails++;
                $display("FAIL R7: actual=%b expected=%b", res[5], ((a + b) < (c + d)));
            end
        end
    endtask

    // R8: swapping within a pair has no effect
    task automatic t_swap();
        for (int i = 0; i < 64; i++) begin
            int a, b, c, d, first;
            a = (i * 9) % 16 - 8;  b = (i * 13) % 16 - 8;
            c = (i * 5) % 16 - 8;  d = (i * 3) % 16 - 8;
            drive(a, b, c, d);
            first = got_val();
            drive(b, a, d, c);
            expect_val("R8", first);
        end
    endtask

    // R1: exhaustive sweep
    task automatic t_sweep();
        for (int i = 0; i < 65536; i++) begin
            logic [15:0] v;
            v = 16'(i);
            a_in = v[15:12]; b_in = v[11:8]; c_in = v[7:4]; d_in = v[3:0];
            #1;
            expect_val("R1", model(v[15:12], v[11:8], v[7:4], v[3:0]));
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=%0d cycles expected=below 150000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        a_in = '0; b_in = '0; c_in = '0; d_in = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        t_idle();
        t_signed_read();
        t_extremes();
        t_balanced();
        t_no_clock();
        t_sign_bit();
        t_swap();
        t_sweep();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule